// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Bank

This block turns transitions on a bank of already-synchronized input pins into interrupt events. Each pin has a control word, and a two-bit trigger field inside that word picks which transitions count: rising, falling, both, or none. A selected transition sets a sticky status bit for that pin. Software clears status bits by writing ones. A per-pin mask hides pins from the single bank interrupt line. The mask has a write-one-to-set port and a separate write-one-to-clear port, so no read-modify-write is needed.

Status bits record events whether or not the pin is masked. The bank interrupt is high whenever any status bit is set on an unmasked pin. Only transitions are detected; level triggering, address decode and debounce sit outside this block. Three write strobes share one data bus. The register interface outside the block decodes bus accesses into these strobes.

Top module: `gpio_eint_ctrl`

## Requirements
- R1: While reset is active and at the first sample after it, every status bit reads 0, every mask bit reads 1 and the interrupt is 0.
- R2: The trigger field is bits 4:3 of each pin's 9-bit control word, with pin i at bits 9i+8 down to 9i of `pin_ctrl`. Code 1 sets the pin's status bit at the clock edge where the pin is sampled 1 after being sampled 0 on the previous edge.
- R3: Code 2 sets the status bit when the pin is sampled 0 after being sampled 1.
- R4: Code 3 sets the status bit on either transition.
- R5: Code 0 disables detection, so transitions on that pin leave its status bit unchanged.
- R6: Status bits are sticky. A cycle with `sts_clr_wr` high clears exactly the status bits where `wr_data` is 1 and leaves all other status bits unchanged.
- R7: A cycle with `msk_set_wr` high sets the mask bits where `wr_data` is 1.
- R8: A cycle with `msk_clr_wr` high clears the mask bits where `wr_data` is 1. If both mask strobes are high for the same bit, the set wins.
- R9: `irq` is the OR over all pins of (status AND NOT mask), in the same cycle with the default `IRQ_REG = 0`.
- R10: When a selected transition and a status clear of the same bit fall on the same clock edge, the bit ends up set.
- R11: Status bits latch while masked, and `irq` rises as soon as a pending pin is unmasked.
- R12: No transition is reported at the first clock edge after reset, because no earlier pin sample exists yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Synchronized pin levels |
| pin_ctrl | input | NUM_PINS*CTRL_W | Per-pin control words; the trigger field sits at TRIG_LSB+1:TRIG_LSB |
| wr_data | input | NUM_PINS | Bit data shared by the three write strobes |
| sts_clr_wr | input | 1 | Clear status bits where wr_data is 1 |
| msk_set_wr | input | 1 | Set mask bits where wr_data is 1 |
| msk_clr_wr | input | 1 | Clear mask bits where wr_data is 1 |
| sts_o | output | NUM_PINS | Sticky status bits |
| msk_o | output | NUM_PINS | Mask bits (1 = masked) |
| irq | output | 1 | Bank interrupt |

## Verification
Two pairs of operations can fall on the same clock edge. The first pair is a pin transition and a software clear of that pin's status bit. The bench makes a second rising edge on a pin whose bit is already set, and it pulses the clear strobe on that same edge. It then expects the bit to still read 1. It also runs a control case, a clear with no edge, which must read 0. The second pair is the two mask strobes. The bench pulses both on a bit that was unmasked beforehand and expects the bit to read masked afterwards.

// File: rtl/gpio_eint_pkg.sv
package gpio_eint_pkg;

   typedef enum logic [1:0] {
      TRIG_OFF  = 2'd0,
      TRIG_RISE = 2'd1,
      TRIG_FALL = 2'd2,
      TRIG_BOTH = 2'd3
   } trig_e;

   localparam int TRIG_BITS = 2;

endpackage

// File: rtl/gpio_eint_edge.sv
module gpio_eint_edge
   import gpio_eint_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 armed,
   input  logic                 pin,
   input  logic [TRIG_BITS-1:0] trig,
   output logic                 evt
);

   logic prev_q;
   logic rise;
   logic fall;
   trig_e mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pin;
   end

   assign mode = trig_e'(trig);
   assign rise = pin & ~prev_q;
   assign fall = ~pin & prev_q;

   always_comb begin
      unique case (mode)
         TRIG_RISE: evt = armed & rise;
         TRIG_FALL: evt = armed & fall;
         TRIG_BOTH: evt = armed & (rise | fall);
         default:   evt = 1'b0;
      endcase
   end

endmodule

// File: rtl/gpio_eint_regs.sv
module gpio_eint_regs #(
   parameter int NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] evt,
   input  logic [NUM_PINS-1:0] wr_data,
   input  logic                sts_clr_wr,
   input  logic                msk_set_wr,
   input  logic                msk_clr_wr,
   output logic [NUM_PINS-1:0] sts_q,
   output logic [NUM_PINS-1:0] msk_q
);

   logic [NUM_PINS-1:0] sts_clr_bits;
   logic [NUM_PINS-1:0] msk_set_bits;
   logic [NUM_PINS-1:0] msk_clr_bits;

   assign sts_clr_bits = sts_clr_wr ? wr_data : '0;
   assign msk_set_bits = msk_set_wr ? wr_data : '0;
   assign msk_clr_bits = msk_clr_wr ? wr_data : '0;

   // a new event overrides a clear of the same bit in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= (sts_q & ~sts_clr_bits) | evt;
   end

   // set has priority over clear: masking is the safe outcome
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) msk_q <= '1;
      else        msk_q <= (msk_q & ~msk_clr_bits) | msk_set_bits;
   end

endmodule

// File: rtl/gpio_eint_irq.sv
module gpio_eint_irq #(
   parameter int NUM_PINS = 32,
   parameter bit IRQ_REG  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] sts,
   input  logic [NUM_PINS-1:0] msk,
   output logic                irq
);

   logic pend;

   assign pend = |(sts & ~msk);

   if (IRQ_REG) begin : g_flop
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pend;
      end
      assign irq = irq_q;
   end else begin : g_comb
      assign irq = pend;
   end

endmodule

// File: rtl/gpio_eint_ctrl.sv
module gpio_eint_ctrl
   import gpio_eint_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int CTRL_W   = 9,
   parameter int TRIG_LSB = 3,
   parameter bit IRQ_REG  = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PINS-1:0]        pin_in,
   input  logic [NUM_PINS*CTRL_W-1:0] pin_ctrl,
   input  logic [NUM_PINS-1:0]        wr_data,
   input  logic                       sts_clr_wr,
   input  logic                       msk_set_wr,
   input  logic                       msk_clr_wr,
   output logic [NUM_PINS-1:0]        sts_o,
   output logic [NUM_PINS-1:0]        msk_o,
   output logic                       irq
);

   localparam int TRIG_MSB = TRIG_LSB + TRIG_BITS - 1;

   if (NUM_PINS < 1 || NUM_PINS > 64) begin : g_bad_pins
      $error("gpio_eint_ctrl: NUM_PINS must be 1..64");
   end
   if (TRIG_MSB >= CTRL_W) begin : g_bad_field
      $error("gpio_eint_ctrl: trigger field exceeds control word");
   end

   logic                armed_q;
   logic [NUM_PINS-1:0] evt;
   logic [NUM_PINS-1:0] sts_q;
   logic [NUM_PINS-1:0] msk_q;

   // pin history only becomes meaningful after one sample
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      gpio_eint_edge u_edge (
         .clk   (clk),
         .rst_n (rst_n),
         .armed (armed_q),
         .pin   (pin_in[i]),
         .trig  (pin_ctrl[i*CTRL_W+TRIG_LSB +: TRIG_BITS]),
         .evt   (evt[i])
      );
   end

   gpio_eint_regs #(.NUM_PINS(NUM_PINS)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt),
      .wr_data    (wr_data),
      .sts_clr_wr (sts_clr_wr),
      .msk_set_wr (msk_set_wr),
      .msk_clr_wr (msk_clr_wr),
      .sts_q      (sts_q),
      .msk_q      (msk_q)
   );

   gpio_eint_irq #(.NUM_PINS(NUM_PINS), .IRQ_REG(IRQ_REG)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .sts   (sts_q),
      .msk   (msk_q),
      .irq   (irq)
   );

   assign sts_o = sts_q;
   assign msk_o = msk_q;

endmodule

// File: rtl/gpio_eint_ctrl_chk.sv
module gpio_eint_ctrl_chk #(
   parameter int NUM_PINS = 32,
   parameter int CTRL_W   = 9,
   parameter int TRIG_LSB = 3,
   parameter bit IRQ_REG  = 1'b0
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NUM_PINS-1:0]        pin_in,
   input logic [NUM_PINS*CTRL_W-1:0] pin_ctrl,
   input logic [NUM_PINS-1:0]        wr_data,
   input logic                       sts_clr_wr,
   input logic                       msk_set_wr,
   input logic                       msk_clr_wr,
   input logic [NUM_PINS-1:0]        sts_o,
   input logic [NUM_PINS-1:0]        msk_o,
   input logic                       irq
);

   logic [NUM_PINS-1:0] trig_on;

   always_comb begin
      for (int i = 0; i < NUM_PINS; i++)
         trig_on[i] = |pin_ctrl[i*CTRL_W+TRIG_LSB +: 2];
   end

   // R6: without a clear strobe no status bit can fall
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !sts_clr_wr |=> ((~sts_o & $past(sts_o)) == '0));

   // R5: a pin whose trigger is off never gains a status bit
   a_r5_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((sts_o & ~$past(sts_o) & ~$past(trig_on)) == '0));

   // R12: a new status bit needs a pin change between the two samples
   a_r12_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((sts_o & ~$past(sts_o) & ~($past(pin_in) ^ $past(pin_in, 2))) == '0));

   // R7: set strobe masks the written bits
   a_r7_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
      msk_set_wr |=> ((msk_o & $past(wr_data)) == $past(wr_data)));

   // R8: clear strobe alone unmasks the written bits
   a_r8_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (msk_clr_wr && !msk_set_wr) |=> ((msk_o & $past(wr_data)) == '0));

   // R9: interrupt tracks pending unmasked status
   if (!IRQ_REG) begin : g_comb_chk
      a_r9_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
         irq == ((sts_o & ~msk_o) != '0));
   end

endmodule

bind gpio_eint_ctrl gpio_eint_ctrl_chk #(
   .NUM_PINS (NUM_PINS),
   .CTRL_W   (CTRL_W),
   .TRIG_LSB (TRIG_LSB),
   .IRQ_REG  (IRQ_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pin_in     (pin_in),
   .pin_ctrl   (pin_ctrl),
   .wr_data    (wr_data),
   .sts_clr_wr (sts_clr_wr),
   .msk_set_wr (msk_set_wr),
   .msk_clr_wr (msk_clr_wr),
   .sts_o      (sts_o),
   .msk_o      (msk_o),
   .irq        (irq)
);

// File: tb/gpio_eint_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_eint_ctrl_bench;

   localparam int N  = 32;
   localparam int CW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pin_in = '0;
   logic [N*CW-1:0] pin_ctrl = '0;
   logic [N-1:0]  wr_data = '0;
   logic          sts_clr_wr = 1'b0;
   logic          msk_set_wr = 1'b0;
   logic          msk_clr_wr = 1'b0;
   logic [N-1:0]  sts_o;
   logic [N-1:0]  msk_o;
   logic          irq;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   gpio_eint_ctrl u_gpio_eint_ctrl (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_ctrl(pin_ctrl),
      .wr_data(wr_data), .sts_clr_wr(sts_clr_wr), .msk_set_wr(msk_set_wr),
      .msk_clr_wr(msk_clr_wr), .sts_o(sts_o), .msk_o(msk_o), .irq(irq)
   );

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic set_trig(input int p, input logic [1:0] t);
      pin_ctrl[p*CW+3 +: 2] = t;
   endtask

   // one-cycle write pulse; effects visible after the following edge
   task automatic wr(input logic s_clr, input logic m_set, input logic m_clr, input logic [N-1:0] d);
      sts_clr_wr = s_clr; msk_set_wr = m_set; msk_clr_wr = m_clr; wr_data = d;
      step();
      sts_clr_wr = 1'b0; msk_set_wr = 1'b0; msk_clr_wr = 1'b0; wr_data = '0;
   endtask

   task automatic t_reset();
      for (int p = 0; p < N; p++) set_trig(p, 2'd1);
      pin_in = '1;
      rst_n = 1'b0;
      step(); step();
      chk("R1 status in reset", sts_o, '0);
      chk("R1 mask in reset", msk_o, '1);
      chk("R1 irq in reset", {31'd0, irq}, '0);
      rst_n = 1'b1;
      step();
      chk("R12 no event at first edge", sts_o, '0);
      chk("R1 mask after reset", msk_o, '1);
      step();
      chk("R12 still quiet", sts_o, '0);
   endtask

   task automatic t_modes();
      pin_ctrl = '0;
      set_trig(0, 2'd1); set_trig(1, 2'd2); set_trig(2, 2'd3); set_trig(3, 2'd0);
      pin_in = '0;
      step();
      chk("R3 falling on pins 1,2", sts_o, 32'h0000_0006);
      wr(1'b1, 1'b0, 1'b0, '1);
      chk("R6 clear all", sts_o, '0);
      pin_in = '1;
      step();
      chk("R2 R4 rising on pins 0,2; R5 pin 3 silent", sts_o, 32'h0000_0005);
      step();
      chk("R6 sticky", sts_o, 32'h0000_0005);
      wr(1'b1, 1'b0, 1'b0, 32'h0000_0001);
      chk("R6 partial clear", sts_o, 32'h0000_0004);
   endtask

   task automatic t_mask_irq();
      chk("R11 masked pending gives no irq", {31'd0, irq}, '0);
      wr(1'b0, 1'b0, 1'b1, 32'h0000_0001);
      chk("R8 unmask bit0", msk_o, ~32'h0000_0001);
      chk("R9 irq with nothing pending unmasked", {31'd0, irq}, '0);
      wr(1'b0, 1'b0, 1'b1, 32'h0000_0004);
      chk("R11 irq on unmask of pending pin", {31'd0, irq}, 32'd1);
      wr(1'b0, 1'b1, 1'b0, 32'h0000_0004);
      chk("R7 mask bit2", msk_o, ~32'h0000_0001);
      chk("R9 irq drops when masked", {31'd0, irq}, '0);
      wr(1'b0, 1'b0, 1'b1, 32'h0000_0020);
      chk("R8 unmask bit5", msk_o, ~32'h0000_0021);
      wr(1'b0, 1'b1, 1'b1, 32'h0000_0020);
      chk("R8 set wins over clear", msk_o, ~32'h0000_0001);
   endtask

   task automatic t_collide();
      // bit0: rising trigger; drive a fresh rise while clearing
      pin_in[0] = 1'b0; step();
      pin_in[0] = 1'b1; step();
      chk("R2 bit0 set by rise", {31'd0, sts_o[0]}, 32'd1);
      chk("R9 irq from unmasked bit0", {31'd0, irq}, 32'd1);
      pin_in[0] = 1'b0; step();
      pin_in[0] = 1'b1;
      wr(1'b1, 1'b0, 1'b0, 32'h0000_0001);
      chk("R10 edge beats clear", {31'd0, sts_o[0]}, 32'd1);
      wr(1'b1, 1'b0, 1'b0, 32'h0000_0001);
      chk("R6 clear without edge", {31'd0, sts_o[0]}, '0);
      chk("R9 irq falls after clear", {31'd0, irq}, '0);
   endtask

   initial begin
      t_reset();
      t_modes();
      t_mask_irq();
      t_collide();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #50000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule